// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block gathers every interrupt source of a UART with receive and transmit FIFOs and turns them into a raw status word, a masked status word and one combined interrupt line. It watches the FIFO fill levels against programmable trigger points, and it takes in single-cycle event pulses from the receive shifter: character done, framing error, parity error and break. It also watches a bit-period tick, a transmitter-busy flag and a CTS change pulse. The shifters, the baud generator and the FIFO storage sit outside the block and only report through these inputs.

Software uses a small four-word register window. Word 0 returns the raw status. Word 1 holds the mask. Word 2 returns raw AND mask. Word 3 is a write-one-to-clear port. Error and event bits are sticky. The transmit and receive flags follow the FIFO level and can be dismissed by software. The receive timeout counts bit periods of silence while data waits in the receive FIFO.

Three small state machines carry the timing. The level-flag machine, with one instance for transmit and one for receive, has the states LV_OFF, LV_RAISED and LV_CLEARED:
- LV_OFF goes to LV_RAISED when the condition is true.
- LV_RAISED goes to LV_OFF when the condition drops, and to LV_CLEARED on a software clear.
- LV_CLEARED goes to LV_OFF when the condition drops.

The timeout machine has the states TO_IDLE, TO_COUNT and TO_FIRED:
- TO_IDLE goes to TO_COUNT once the mask is on and the receive FIFO holds data.
- TO_COUNT goes to TO_FIRED on the 32nd bit tick with no received character, and back to TO_IDLE if the mask drops or the FIFO empties.
- TO_FIRED goes to TO_COUNT on a software clear, and to TO_IDLE if the mask drops or the FIFO empties.

The end-of-transmission machine has the states EOT_SENDING and EOT_DRAINED:
- EOT_SENDING goes to EOT_DRAINED when the transmit FIFO is empty and the shifter is idle, and this transition sets the status bit.
- EOT_DRAINED goes back to EOT_SENDING when data or activity reappears.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Raw status bit positions: CTS change 1, receive 4, transmit 5, receive timeout 6, framing 7, parity 8, break 9, overrun 10, end of transmission 11. Every other bit reads 0. The mask word keeps only these nine bits. Raw status and mask are 0 while reset is held. Register words: 0 raw, 1 mask, 2 masked, 3 clear.
- R2: The masked word equals raw AND mask, and `irq` is 1 exactly when the masked word is nonzero.
- R3: A pulse on framing, parity, break or CTS change sets its raw bit on the next edge. The bit stays set until a 1 is written to that bit position in word 3, and writing 1 to one bit leaves the others alone.
- R4: Overrun sets when a character completes while the receive FIFO is full. Full means the level equals the depth with FIFOs on, or a level of 1 with FIFOs off.
- R5: End of transmission sets once, when the transmit FIFO becomes empty and the transmitter is no longer busy. It stays set until cleared.
- R6: With FIFOs on, the transmit flag is 1 while the TX level is at or below the TX trigger. Trigger select codes 0,1,2,3,4 give depth×1/8, 1/4, 1/2, 3/4, 7/8, and codes 5–7 act as code 4.
- R7: With FIFOs on, the receive flag is 1 while the RX level is at or above the RX trigger, which uses the same code table.
- R8: With FIFOs off, the transmit flag is 1 when the TX level is 0, and the receive flag is 1 when the RX level is nonzero.
- R9: Writing 1 to bit 5 or bit 4 in word 3 drops that flag even while its condition holds. The flag returns only after the condition has gone false and come back true.
- R10: With mask bit 6 set and the RX FIFO not empty, the timeout bit sets on the 32nd bit tick with no character completion in between. A completed character restarts the count.
- R11: The timeout bit never sets while mask bit 6 is 0. It clears when the RX FIFO is empty or on a write of 1 to bit 6 in word 3.
- R12: When a set event and a clear of the same bit fall in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: FIFOs active, 0: single-location mode |
| tx_level | input | LVL_W | Transmit FIFO fill count |
| rx_level | input | LVL_W | Receive FIFO fill count |
| tx_trig_sel | input | 3 | Transmit trigger code |
| rx_trig_sel | input | 3 | Receive trigger code |
| rx_done | input | 1 | Pulse: a character finished reception |
| rx_frame_err | input | 1 | Pulse: stop bit was 0 |
| rx_parity_err | input | 1 | Pulse: parity mismatch |
| rx_break | input | 1 | Pulse: line held low beyond a full character |
| bit_tick | input | 1 | One pulse per bit period |
| tx_busy | input | 1 | Transmit shifter still sending |
| cts_change | input | 1 | Pulse: CTS input toggled |
| reg_addr | input | 2 | Register word select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word |
| irq | output | 1 | Combined interrupt |

## Verification
The bench drives the trigger table at the exact boundary levels, one below, at and one above each threshold, in both FIFO modes. An off-by-one compare or a wrong fraction would show up there as a flag on the wrong side of its trigger. It counts 31 and then 32 ticks, with a character completing midway. A counter that does not restart, or that fires one tick early, would set the timeout bit too soon. It also holds the timeout mask off while data waits, where a design that treats the mask as a plain output mask would report a raw bit. Finally it pairs clears with simultaneous set events and with conditions that stay true. A design that lets the clear win would lose events, and one that re-raises a dismissed level flag at once would keep the interrupt line stuck.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
    localparam int REG_W = 32;

    localparam int B_CTS = 1;
    localparam int B_RX  = 4;
    localparam int B_TX  = 5;
    localparam int B_TO  = 6;
    localparam int B_FE  = 7;
    localparam int B_PE  = 8;
    localparam int B_BE  = 9;
    localparam int B_OE  = 10;
    localparam int B_EOT = 11;

    localparam logic [REG_W-1:0] IMPL_MASK = 32'h0000_0FF2;

    localparam int N_STICKY = 6;

    typedef enum logic [1:0] {
        A_RAW    = 2'd0,
        A_MASK   = 2'd1,
        A_MASKED = 2'd2,
        A_CLEAR  = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        LV_OFF     = 2'd0,
        LV_RAISED  = 2'd1,
        LV_CLEARED = 2'd2
    } lvl_state_e;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } to_state_e;

    typedef enum logic {
        EOT_SENDING = 1'b0,
        EOT_DRAINED = 1'b1
    } eot_state_e;

    // Trigger point for a 3-bit select code, as a fraction of the FIFO depth
    function automatic int trig_level(input logic [2:0] sel, input int depth);
        int r;
        case (sel)
            3'd0:    r = depth / 8;
            3'd1:    r = depth / 4;
            3'd2:    r = depth / 2;
            3'd3:    r = (depth * 3) / 4;
            default: r = (depth * 7) / 8;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/uart_irq_level.sv
`timescale 1ns/1ps
module uart_irq_level #(
    parameter int DEPTH = 16,
    parameter bit IS_TX = 1'b1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] level,
    input  logic [2:0]       trig_sel,
    input  logic             clr,
    output logic             flag
);
    import uart_irq_pkg::*;

    lvl_state_e       state_q, state_n;
    logic [LVL_W-1:0] trig;
    logic             cond;

    assign trig = LVL_W'(trig_level(trig_sel, DEPTH));

    generate
        if (IS_TX) begin : g_tx
            always_comb cond = fifo_en ? (level <= trig) : (level == '0);
        end else begin : g_rx
            always_comb cond = fifo_en ? (level >= trig) : (level != '0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LV_OFF;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            LV_OFF:     if (cond) state_n = LV_RAISED;
            LV_RAISED:  if (!cond) state_n = LV_OFF;
                        else if (clr) state_n = LV_CLEARED;
            LV_CLEARED: if (!cond) state_n = LV_OFF;
            default:    state_n = LV_OFF;
        endcase
    end

    always_comb flag = (state_q == LV_RAISED);

    AST_FLAG_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> $past(cond)); // R9
    AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == LV_RAISED && $past(clr)) |-> !flag); // R9
endmodule

// File: rtl/uart_irq_rxto.sv
`timescale 1ns/1ps
module uart_irq_rxto #(
    parameter int DEPTH   = 16,
    parameter int TO_BITS = 32,
    localparam int LVL_W  = $clog2(DEPTH + 1),
    localparam int CNT_W  = $clog2(TO_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_done,
    input  logic             bit_tick,
    input  logic             clr,
    output logic             fired
);
    import uart_irq_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_BITS - 1);

    to_state_e        state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             live;

    assign live = enable && (rx_level != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TO_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            TO_IDLE: begin
                cnt_n = '0;
                if (live) state_n = TO_COUNT;
            end
            TO_COUNT: begin
                if (!live) begin
                    state_n = TO_IDLE;
                    cnt_n   = '0;
                end else if (rx_done) begin
                    cnt_n = '0;
                end else if (bit_tick) begin
                    if (cnt_q == LAST) begin
                        state_n = TO_FIRED;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            TO_FIRED: begin
                cnt_n = '0;
                if (!live)    state_n = TO_IDLE;
                else if (clr) state_n = TO_COUNT;
            end
            default: begin
                state_n = TO_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    always_comb fired = (state_q == TO_FIRED);

    AST_TO_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        fired |-> $past(enable)); // R11
    AST_TO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fired |-> $past(rx_level != '0)); // R10
    AST_TO_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fired) |-> $past(bit_tick && !rx_done)); // R10
endmodule

// File: rtl/uart_irq_eot.sv
`timescale 1ns/1ps
module uart_irq_eot #(
    parameter int DEPTH  = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             tx_busy,
    output logic             eot_set
);
    import uart_irq_pkg::*;

    eot_state_e state_q, state_n;
    logic       drained;

    assign drained = (tx_level == '0) && !tx_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EOT_DRAINED;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            EOT_SENDING: if (drained)  state_n = EOT_DRAINED;
            EOT_DRAINED: if (!drained) state_n = EOT_SENDING;
            default:     state_n = EOT_DRAINED;
        endcase
    end

    always_comb eot_set = (state_q == EOT_SENDING) && drained;
endmodule

// File: rtl/uart_irq_ctrl.sv
`timescale 1ns/1ps
module uart_irq_ctrl #(
    parameter int DEPTH   = 16,
    parameter int TO_BITS = 32,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [2:0]       tx_trig_sel,
    input  logic [2:0]       rx_trig_sel,
    input  logic             rx_done,
    input  logic             rx_frame_err,
    input  logic             rx_parity_err,
    input  logic             rx_break,
    input  logic             bit_tick,
    input  logic             tx_busy,
    input  logic             cts_change,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq
);
    import uart_irq_pkg::*;

    localparam int STICKY_IDX [N_STICKY] = '{B_CTS, B_FE, B_PE, B_BE, B_OE, B_EOT};
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    reg_addr_e             addr;
    logic [REG_W-1:0]      mask_q;
    logic [REG_W-1:0]      clr_v;
    logic [REG_W-1:0]      raw;
    logic [REG_W-1:0]      masked;
    logic [N_STICKY-1:0]   sticky_q, sticky_n, set_v;
    logic                  overrun;
    logic                  eot_set;
    logic                  tx_flag, rx_flag, to_fired;

    assign addr    = reg_addr_e'(reg_addr);
    assign clr_v   = (reg_wr && addr == A_CLEAR) ? (reg_wdata & IMPL_MASK) : '0;
    assign overrun = rx_done && (fifo_en ? (rx_level == FULL) : (rx_level != '0));

    // Level flags, one instance per direction
    generate
        for (genvar d = 0; d < 2; d++) begin : g_dir
            if (d == 0) begin : g_t
                uart_irq_level #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_lvl (
                    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
                    .level(tx_level), .trig_sel(tx_trig_sel),
                    .clr(clr_v[B_TX]), .flag(tx_flag));
            end else begin : g_r
                uart_irq_level #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_lvl (
                    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
                    .level(rx_level), .trig_sel(rx_trig_sel),
                    .clr(clr_v[B_RX]), .flag(rx_flag));
            end
        end
    endgenerate

    uart_irq_rxto #(.DEPTH(DEPTH), .TO_BITS(TO_BITS)) u_rxto (
        .clk(clk), .rst_n(rst_n), .enable(mask_q[B_TO]),
        .rx_level(rx_level), .rx_done(rx_done), .bit_tick(bit_tick),
        .clr(clr_v[B_TO]), .fired(to_fired));

    uart_irq_eot #(.DEPTH(DEPTH)) u_eot (
        .clk(clk), .rst_n(rst_n), .tx_level(tx_level),
        .tx_busy(tx_busy), .eot_set(eot_set));

    // Sticky event bits: a set in the same cycle as a clear wins
    always_comb begin
        set_v = {eot_set, overrun, rx_break, rx_parity_err, rx_frame_err, cts_change};
        for (int i = 0; i < N_STICKY; i++) begin
            sticky_n[i] = set_v[i] | (sticky_q[i] & ~clr_v[STICKY_IDX[i]]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
            mask_q   <= '0;
        end else begin
            sticky_q <= sticky_n;
            if (reg_wr && addr == A_MASK) mask_q <= reg_wdata & IMPL_MASK;
        end
    end

    always_comb begin
        raw = '0;
        for (int i = 0; i < N_STICKY; i++) raw[STICKY_IDX[i]] = sticky_q[i];
        raw[B_TX] = tx_flag;
        raw[B_RX] = rx_flag;
        raw[B_TO] = to_fired;
    end

    assign masked = raw & mask_q;
    assign irq    = |masked;

    always_comb begin
        unique case (addr)
            A_RAW:    reg_rdata = raw;
            A_MASK:   reg_rdata = mask_q;
            A_MASKED: reg_rdata = masked;
            A_CLEAR:  reg_rdata = '0;
            default:  reg_rdata = '0;
        endcase
    end

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0)); // R2
    AST_STICKY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw[B_FE]) |-> $past(clr_v[B_FE])); // R3
    AST_OVERRUN_ON_RX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw[B_OE]) |-> $past(rx_done)); // R4
    AST_EOT_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw[B_EOT]) |-> $past(tx_level == '0 && !tx_busy)); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_frame_err) |-> raw[B_FE]); // R12
endmodule

// File: tb/uart_irq_ctrl_bench.sv
`timescale 1ns/1ps
module uart_irq_ctrl_bench;
    localparam int DEPTH = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fifo_en = 1'b0;
    logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
    logic [2:0]       tx_trig_sel = '0, rx_trig_sel = '0;
    logic             rx_done = 0, rx_frame_err = 0, rx_parity_err = 0, rx_break = 0;
    logic             bit_tick = 0, tx_busy = 0, cts_change = 0;
    logic [1:0]       reg_addr = '0;
    logic             reg_wr = 0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    uart_irq_ctrl #(.DEPTH(DEPTH)) u_uart_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel),
        .rx_done(rx_done), .rx_frame_err(rx_frame_err),
        .rx_parity_err(rx_parity_err), .rx_break(rx_break),
        .bit_tick(bit_tick), .tx_busy(tx_busy), .cts_change(cts_change),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq));

    // {fifo_en, tx_sel, tx_level, rx_sel, rx_level, exp_tx, exp_rx}
    localparam logic [18:0] VEC [12] = '{
        {1'b1, 3'd0, 5'd2,  3'd0, 5'd2,  1'b1, 1'b1},
        {1'b1, 3'd0, 5'd3,  3'd0, 5'd1,  1'b0, 1'b0},
        {1'b1, 3'd2, 5'd8,  3'd2, 5'd7,  1'b1, 1'b0},
        {1'b1, 3'd2, 5'd9,  3'd2, 5'd8,  1'b0, 1'b1},
        {1'b1, 3'd3, 5'd12, 3'd3, 5'd12, 1'b1, 1'b1},
        {1'b1, 3'd4, 5'd14, 3'd4, 5'd13, 1'b1, 1'b0},
        {1'b1, 3'd4, 5'd15, 3'd4, 5'd14, 1'b0, 1'b1},
        {1'b1, 3'd7, 5'd14, 3'd7, 5'd14, 1'b1, 1'b1},
        {1'b1, 3'd1, 5'd0,  3'd1, 5'd16, 1'b1, 1'b1},
        {1'b0, 3'd0, 5'd0,  3'd0, 5'd0,  1'b1, 1'b0},
        {1'b0, 3'd0, 5'd1,  3'd0, 5'd1,  1'b0, 1'b1},
        {1'b0, 3'd4, 5'd3,  3'd4, 5'd0,  1'b0, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        cyc(3);
        // R1: reset state
        rd(2'd0, d); chk("R1", "raw in reset", d, 32'h0);
        rd(2'd1, d); chk("R1", "mask in reset", d, 32'h0);
        chk("R2", "irq in reset", {31'b0, irq}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        cyc(2);

        // R6 R7 R8: trigger table walk
        for (int v = 0; v < 12; v++) begin
            @(negedge clk);
            fifo_en     = VEC[v][18];
            tx_trig_sel = VEC[v][17:15];
            tx_level    = VEC[v][14:10];
            rx_trig_sel = VEC[v][9:7];
            rx_level    = VEC[v][6:2];
            cyc(2);
            rd(2'd0, d);
            chk(VEC[v][18] ? "R6" : "R8", $sformatf("tx flag row %0d", v), {31'b0, d[5]}, {31'b0, VEC[v][1]});
            chk(VEC[v][18] ? "R7" : "R8", $sformatf("rx flag row %0d", v), {31'b0, d[4]}, {31'b0, VEC[v][0]});
        end

        // settle: FIFOs on, TX above trigger, RX empty, clear all events
        @(negedge clk); fifo_en = 1; tx_trig_sel = 0; tx_level = 5; rx_trig_sel = 4; rx_level = 0;
        cyc(2);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd0, d); chk("R1", "raw all clear", d, 32'h0);

        // R1 mask keeps only implemented bits
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); chk("R1", "mask readback", d, 32'h0000_0FF2);
        wr(2'd1, 32'h0);

        // R3: sticky events and independent clears
        @(negedge clk); rx_frame_err = 1; rx_parity_err = 1; rx_break = 1; cts_change = 1;
        @(negedge clk); rx_frame_err = 0; rx_parity_err = 0; rx_break = 0; cts_change = 0;
        cyc(3);
        rd(2'd0, d); chk("R3", "sticky set", d, 32'h0000_0382);
        wr(2'd3, 32'h0000_0080);
        rd(2'd0, d); chk("R3", "clear framing only", d, 32'h0000_0302);

        // R2: masked view and irq
        wr(2'd1, 32'h0000_0100);
        rd(2'd2, d); chk("R2", "masked word", d, 32'h0000_0100);
        chk("R2", "irq with mask", {31'b0, irq}, 32'h1);
        wr(2'd1, 32'h0000_0080);
        chk("R2", "irq masked off", {31'b0, irq}, 32'h0);
        wr(2'd1, 32'h0);
        wr(2'd3, 32'h0000_0302);

        // R12: framing pulse together with its clear
        @(negedge clk); rx_frame_err = 1;
        @(negedge clk); rx_frame_err = 0;
        @(negedge clk); reg_addr = 2'd3; reg_wdata = 32'h80; reg_wr = 1; rx_frame_err = 1;
        @(negedge clk); reg_wr = 0; rx_frame_err = 0;
        rd(2'd0, d); chk("R12", "set beats clear", d & 32'h80, 32'h80);
        wr(2'd3, 32'h80);

        // R4: overrun
        @(negedge clk); rx_level = 15; rx_done = 1;
        @(negedge clk); rx_done = 0;
        rd(2'd0, d); chk("R4", "no overrun below full", d & 32'h400, 32'h0);
        @(negedge clk); rx_level = 16; rx_done = 1;
        @(negedge clk); rx_done = 0;
        rd(2'd0, d); chk("R4", "overrun when full", d & 32'h400, 32'h400);
        wr(2'd3, 32'h400);
        @(negedge clk); fifo_en = 0; rx_level = 1; rx_done = 1;
        @(negedge clk); rx_done = 0;
        rd(2'd0, d); chk("R4", "overrun single location", d & 32'h400, 32'h400);
        @(negedge clk); fifo_en = 1; rx_level = 0;
        wr(2'd3, 32'h400);

        // R5: end of transmission
        @(negedge clk); tx_level = 3; tx_busy = 1;
        cyc(1);
        wr(2'd3, 32'h800);
        @(negedge clk); tx_level = 0;
        cyc(2);
        rd(2'd0, d); chk("R5", "still busy", d & 32'h800, 32'h0);
        @(negedge clk); tx_busy = 0;
        @(negedge clk);
        rd(2'd0, d); chk("R5", "drained", d & 32'h800, 32'h800);
        cyc(3);
        rd(2'd0, d); chk("R5", "eot holds", d & 32'h800, 32'h800);
        wr(2'd3, 32'h800);

        // R9: level flag dismiss and re-arm
        @(negedge clk); tx_level = 5;
        cyc(2);
        @(negedge clk); tx_level = 0;
        cyc(2);
        rd(2'd0, d); chk("R9", "tx raised", d & 32'h20, 32'h20);
        wr(2'd3, 32'h20);
        cyc(3);
        rd(2'd0, d); chk("R9", "tx dismissed while cond true", d & 32'h20, 32'h0);
        @(negedge clk); tx_level = 5;
        @(negedge clk); tx_level = 0;
        cyc(2);
        rd(2'd0, d); chk("R9", "tx re-armed", d & 32'h20, 32'h20);
        // R12: condition rises in the clear cycle
        @(negedge clk); tx_level = 5;
        cyc(2);
        @(negedge clk); tx_level = 0; reg_addr = 2'd3; reg_wdata = 32'h20; reg_wr = 1;
        @(negedge clk); reg_wr = 0;
        rd(2'd0, d); chk("R12", "tx rise beats clear", d & 32'h20, 32'h20);

        // R11: timeout blocked by mask
        @(negedge clk); rx_level = 1;
        cyc(2);
        ticks(40);
        rd(2'd0, d); chk("R11", "timeout with mask off", d & 32'h40, 32'h0);

        // R10: timeout count with restart
        wr(2'd1, 32'h40);
        cyc(1);
        ticks(20);
        @(negedge clk); rx_done = 1;
        @(negedge clk); rx_done = 0;
        ticks(31);
        rd(2'd0, d); chk("R10", "31 ticks after char", d & 32'h40, 32'h0);
        ticks(1);
        rd(2'd0, d); chk("R10", "32nd tick fires", d & 32'h40, 32'h40);
        chk("R2", "irq from timeout", {31'b0, irq}, 32'h1);
        wr(2'd3, 32'h40);
        rd(2'd0, d); chk("R11", "clear drops timeout", d & 32'h40, 32'h0);
        ticks(32);
        rd(2'd0, d); chk("R10", "refires after clear", d & 32'h40, 32'h40);
        @(negedge clk); rx_level = 0;
        @(negedge clk);
        rd(2'd0, d); chk("R11", "empty fifo drops timeout", d & 32'h40, 32'h0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule